// File: doc/BRIEF.md
# CAN Frame Transmit Serializer

This block turns one parallel frame request into the unstuffed bit sequence of a CAN 2.0B data or remote frame. The frame can carry an 11-bit standard identifier or a 29-bit extended one. While the block is idle, a request presents the identifier, the extension flag, the remote flag, the length code and a 64-bit payload. The block latches that request. From then on it puts out one frame bit for each bit strobe from the bit-timing logic.

One field sequencer serves both identifier layouts. The 15-bit CRC is accumulated as the bits go out and is then appended. The fixed-form tail follows the CRC. Along with each bit, the block gives a field class so that a downstream stuffing unit knows where stuff bits may be inserted. The CRC is computed over the unstuffed bits only, so any stuff bits added downstream never enter it. During the acknowledge slot the block samples the bus. One strobe after the last end-of-frame bit, it pulses `done` together with either an acknowledge-seen flag or a missing-acknowledge flag.

Top module: `can_tx_serializer`

## Requirements
- R1: While idle (`busy` low), `tx_bit` is 1 (recessive) and `field_class` is 0. A clock edge with `req_valid` high while idle latches the request and raises `busy` from the next cycle on. `req_valid` is ignored while `busy` is high, so the frame in progress is unchanged.
- R2: `tx_bit` changes only on a clock edge where both `busy` and `bit_strobe` are high, and each such edge puts out exactly one frame bit. The first bit after acceptance is a 0 start bit.
- R3: When `req_ide`=0 the header is sent in this order: identifier bits 28..18, most significant bit first; then the remote flag (1 for remote, 0 for data); then a 0 extension bit; then a 0 reserved bit; then the 4 length-code bits, most significant bit first.
- R4: When `req_ide`=1 the header is sent in this order: identifier bits 28..18; then a 1 substitute bit; then a 1 extension bit; then identifier bits 17..0; then the remote flag; then two 0 reserved bits; then the 4 length-code bits.
- R5: A data frame carries min(`req_dlc`, 8) payload bytes. Byte k is `req_data[8k+7:8k]`. Byte 0 is sent first, and each byte goes most significant bit first. A remote frame carries no payload, whatever its length code.
- R6: After the payload (or after the length code when there is no payload), 15 CRC bits are sent most significant bit first. The CRC is computed over every bit from the start bit through the payload. It uses the polynomial x^15+x^14+x^10+x^8+x^7+x^4+x^3+1 (0x4599) and a register cleared to zero at the start of the frame.
- R7: After the CRC, ten bits follow, all 1: the CRC delimiter, the acknowledge slot, the acknowledge delimiter, and seven end-of-frame bits.
- R8: `field_class` gives the class of the bit on `tx_bit`: 0 = idle, 1 = stuffable (start bit through the last CRC bit), 2 = fixed form (CRC delimiter through the last end-of-frame bit).
- R9: `bus_rx` is sampled on the strobe that ends the acknowledge slot. A 0 sample gives `ack_ok`=1, and a 1 sample gives `ack_error`=1. Either flag is a one-cycle pulse issued together with `done`, and the two are never high at the same time.
- R10: On the first strobe after the last end-of-frame bit, `done` pulses for one cycle. In the same cycle `busy` falls, `tx_bit` returns to 1 and `field_class` returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_strobe | input | 1 | One-cycle pulse per bit time |
| req_valid | input | 1 | Frame request, taken only while idle |
| req_ide | input | 1 | 1 = extended identifier |
| req_rtr | input | 1 | 1 = remote frame |
| req_id | input | 29 | Identifier; a standard frame uses bits 28..18 |
| req_dlc | input | 4 | Length code |
| req_data | input | 64 | Payload, byte k at bits 8k+7..8k |
| bus_rx | input | 1 | Sampled bus level |
| tx_bit | output | 1 | Current unstuffed frame bit |
| field_class | output | 2 | Class of the current bit for the stuffer |
| busy | output | 1 | Frame in progress |
| done | output | 1 | End-of-frame pulse |
| ack_ok | output | 1 | Acknowledge seen, pulsed with done |
| ack_error | output | 1 | Acknowledge missing, pulsed with done |

## Verification
A wrong field transition or a miscounted field length shifts every bit that follows it. It shows on `tx_bit` at the very strobe where the sequencer goes astray, and it also moves where `done` falls. A corrupted CRC step stays hidden until the CRC field begins, and then shows in the first CRC bit that differs. A wrong acknowledge sample, or a wrong choice of strobe for it, shows only in `ack_ok` or `ack_error` at the end-of-frame pulse. The bench therefore drives the bus with the bit just sent everywhere except the acknowledge slot.

// File: rtl/can_tx_pkg.sv
package can_tx_pkg;
    localparam int ID_W     = 29;
    localparam int ID_A_W   = 11;
    localparam int ID_B_W   = 18;
    localparam int DLC_W    = 4;
    localparam int CRC_W    = 15;
    localparam int EOF_W    = 7;
    localparam logic [CRC_W-1:0] CRC_POLY = 15'h4599;

    // order matters: every field up to F_DATA feeds the CRC
    typedef enum logic [3:0] {
        F_SOF, F_IDA, F_SRR, F_IDE, F_IDB, F_RTR, F_R1, F_R0,
        F_DLC, F_DATA, F_CRC, F_CDEL, F_ACK, F_ADEL, F_EOF, F_FIN
    } fld_e;

    typedef enum logic [1:0] {
        CLS_IDLE  = 2'd0,
        CLS_STUFF = 2'd1,
        CLS_FIXED = 2'd2
    } cls_e;

    function automatic int cnt_width(input int max_bytes);
        int w;
        w = $clog2(8 * max_bytes);
        return (w > 5) ? w : 5;
    endfunction
endpackage

// File: rtl/can_crc15_step.sv
module can_crc15_step
    import can_tx_pkg::*;
(
    input  logic [CRC_W-1:0] crc_in,
    input  logic             bit_in,
    output logic [CRC_W-1:0] crc_out
);
    logic fb;
    always_comb begin
        fb      = bit_in ^ crc_in[CRC_W-1];
        crc_out = {crc_in[CRC_W-2:0], 1'b0};
        if (fb) crc_out = crc_out ^ CRC_POLY;
    end
endmodule

// File: rtl/can_tx_fieldseq.sv
module can_tx_fieldseq
    import can_tx_pkg::*;
#(
    parameter  int MAX_BYTES = 8,
    localparam int DATA_W    = 8 * MAX_BYTES,
    localparam int DIDX_W    = $clog2(DATA_W),
    localparam int CNT_W     = cnt_width(MAX_BYTES)
) (
    input  fld_e              fld,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              ide,
    input  logic              rtr,
    input  logic [ID_W-1:0]   id,
    input  logic [DLC_W-1:0]  dlc,
    input  logic [DATA_W-1:0] data,
    input  logic [CRC_W-1:0]  crc,
    output logic              bit_o,
    output cls_e              cls_o,
    output logic              last_o,
    output fld_e              nxt_o
);
    localparam int IDX_W = $clog2(ID_W);

    int c;
    int nb;
    int didx;

    always_comb begin
        c    = int'(cnt);
        nb   = rtr ? 0 : ((int'(dlc) > MAX_BYTES) ? MAX_BYTES : int'(dlc));
        didx = 8 * (c / 8) + 7 - (c % 8);

        bit_o = 1'b1;
        case (fld)
            F_SOF:  bit_o = 1'b0;
            F_IDA:  bit_o = id[IDX_W'(ID_W - 1 - c)];
            F_SRR:  bit_o = 1'b1;
            F_IDE:  bit_o = ide;
            F_IDB:  bit_o = id[IDX_W'(ID_B_W - 1 - c)];
            F_RTR:  bit_o = rtr;
            F_R1:   bit_o = 1'b0;
            F_R0:   bit_o = 1'b0;
            F_DLC:  bit_o = dlc[2'(DLC_W - 1 - c)];
            F_DATA: bit_o = data[DIDX_W'(didx)];
            F_CRC:  bit_o = crc[4'(CRC_W - 1 - c)];
            default: bit_o = 1'b1;
        endcase

        if (fld == F_FIN)      cls_o = CLS_IDLE;
        else if (fld <= F_CRC) cls_o = CLS_STUFF;
        else                   cls_o = CLS_FIXED;

        case (fld)
            F_IDA:  last_o = (c == ID_A_W - 1);
            F_IDB:  last_o = (c == ID_B_W - 1);
            F_DLC:  last_o = (c == DLC_W - 1);
            F_DATA: last_o = (c == nb * 8 - 1);
            F_CRC:  last_o = (c == CRC_W - 1);
            F_EOF:  last_o = (c == EOF_W - 1);
            default: last_o = 1'b1;
        endcase

        case (fld)
            F_SOF:  nxt_o = F_IDA;
            F_IDA:  nxt_o = ide ? F_SRR : F_RTR;
            F_SRR:  nxt_o = F_IDE;
            F_IDE:  nxt_o = ide ? F_IDB : F_R0;
            F_IDB:  nxt_o = F_RTR;
            F_RTR:  nxt_o = ide ? F_R1 : F_IDE;
            F_R1:   nxt_o = F_R0;
            F_R0:   nxt_o = F_DLC;
            F_DLC:  nxt_o = (nb == 0) ? F_CRC : F_DATA;
            F_DATA: nxt_o = F_CRC;
            F_CRC:  nxt_o = F_CDEL;
            F_CDEL: nxt_o = F_ACK;
            F_ACK:  nxt_o = F_ADEL;
            F_ADEL: nxt_o = F_EOF;
            F_EOF:  nxt_o = F_FIN;
            default: nxt_o = F_FIN;
        endcase
    end
endmodule

// File: rtl/can_tx_serializer.sv
module can_tx_serializer
    import can_tx_pkg::*;
#(
    parameter  int MAX_BYTES = 8,
    localparam int DATA_W    = 8 * MAX_BYTES,
    localparam int CNT_W     = cnt_width(MAX_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_strobe,
    input  logic              req_valid,
    input  logic              req_ide,
    input  logic              req_rtr,
    input  logic [ID_W-1:0]   req_id,
    input  logic [DLC_W-1:0]  req_dlc,
    input  logic [DATA_W-1:0] req_data,
    input  logic              bus_rx,
    output logic              tx_bit,
    output logic [1:0]        field_class,
    output logic              busy,
    output logic              done,
    output logic              ack_ok,
    output logic              ack_error
);
    typedef struct packed {
        logic              busy;
        fld_e              fld;
        logic [CNT_W-1:0]  cnt;
        logic [CRC_W-1:0]  crc;
        logic              ide;
        logic              rtr;
        logic [ID_W-1:0]   id;
        logic [DLC_W-1:0]  dlc;
        logic [DATA_W-1:0] data;
        logic              tx;
        cls_e              cls;
        logic              ack_dom;
        logic              done;
        logic              ack_ok;
        logic              ack_err;
    } state_t;

    state_t s_d, s_q;

    logic             cur_bit;
    cls_e             cur_cls;
    logic             fld_last;
    fld_e             fld_nxt;
    logic [CRC_W-1:0] crc_nxt;

    can_tx_fieldseq #(.MAX_BYTES(MAX_BYTES)) u_seq (
        .fld    (s_q.fld),
        .cnt    (s_q.cnt),
        .ide    (s_q.ide),
        .rtr    (s_q.rtr),
        .id     (s_q.id),
        .dlc    (s_q.dlc),
        .data   (s_q.data),
        .crc    (s_q.crc),
        .bit_o  (cur_bit),
        .cls_o  (cur_cls),
        .last_o (fld_last),
        .nxt_o  (fld_nxt)
    );

    can_crc15_step u_crc (
        .crc_in  (s_q.crc),
        .bit_in  (cur_bit),
        .crc_out (crc_nxt)
    );

    always_comb begin
        s_d         = s_q;
        s_d.done    = 1'b0;
        s_d.ack_ok  = 1'b0;
        s_d.ack_err = 1'b0;
        if (!s_q.busy) begin
            if (req_valid) begin
                s_d.busy    = 1'b1;
                s_d.fld     = F_SOF;
                s_d.cnt     = '0;
                s_d.crc     = '0;
                s_d.ide     = req_ide;
                s_d.rtr     = req_rtr;
                s_d.id      = req_id;
                s_d.dlc     = req_dlc;
                s_d.data    = req_data;
                s_d.ack_dom = 1'b0;
            end
        end else if (bit_strobe) begin
            if (s_q.fld == F_FIN) begin
                s_d.busy    = 1'b0;
                s_d.tx      = 1'b1;
                s_d.cls     = CLS_IDLE;
                s_d.done    = 1'b1;
                s_d.ack_ok  = s_q.ack_dom;
                s_d.ack_err = !s_q.ack_dom;
            end else begin
                s_d.tx  = cur_bit;
                s_d.cls = cur_cls;
                if (s_q.fld <= F_DATA) s_d.crc = crc_nxt;
                if (s_q.fld == F_ADEL) s_d.ack_dom = !bus_rx;
                if (fld_last) begin
                    s_d.fld = fld_nxt;
                    s_d.cnt = '0;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q    <= '0;
            s_q.tx <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign tx_bit      = s_q.tx;
    assign field_class = s_q.cls;
    assign busy        = s_q.busy;
    assign done        = s_q.done;
    assign ack_ok      = s_q.ack_ok;
    assign ack_error   = s_q.ack_err;
endmodule

// File: rtl/can_tx_serializer_chk.sv
module can_tx_serializer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       bit_strobe,
    input logic       tx_bit,
    input logic [1:0] field_class,
    input logic       busy,
    input logic       done,
    input logic       ack_ok,
    input logic       ack_error
);
    // R1
    idle_recessive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (tx_bit && field_class == 2'd0));

    // R2
    hold_without_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !bit_strobe) |=> $stable(tx_bit));

    // R10
    done_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10
    done_ends_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy) && $past(bit_strobe)));

    // R9
    ack_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ack_ok, ack_error}));

    // R9
    ack_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_ok || ack_error) |-> done);

    // R9
    done_has_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (ack_ok || ack_error));
endmodule

bind can_tx_serializer can_tx_serializer_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bit_strobe  (bit_strobe),
    .tx_bit      (tx_bit),
    .field_class (field_class),
    .busy        (busy),
    .done        (done),
    .ack_ok      (ack_ok),
    .ack_error   (ack_error)
);

// File: tb/tb_can_tx_serializer.sv
module tb_can_tx_serializer;
    localparam int CLK_PERIOD = 10;
    localparam int MAXLEN     = 160;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bit_strobe = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ide = 1'b0;
    logic        req_rtr = 1'b0;
    logic [28:0] req_id = '0;
    logic [3:0]  req_dlc = '0;
    logic [63:0] req_data = '0;
    logic        bus_rx = 1'b1;
    logic        tx_bit;
    logic [1:0]  field_class;
    logic        busy, done, ack_ok, ack_error;

    int n_cmp = 0;
    int n_bad = 0;

    logic       exp_b [MAXLEN];
    logic [1:0] exp_c [MAXLEN];
    int         exp_len;
    int         hdr_len;
    int         pay_bits;

    always #(CLK_PERIOD/2) clk = ~clk;

    can_tx_serializer dut (
        .clk(clk), .rst_n(rst_n), .bit_strobe(bit_strobe), .req_valid(req_valid),
        .req_ide(req_ide), .req_rtr(req_rtr), .req_id(req_id), .req_dlc(req_dlc),
        .req_data(req_data), .bus_rx(bus_rx), .tx_bit(tx_bit), .field_class(field_class),
        .busy(busy), .done(done), .ack_ok(ack_ok), .ack_error(ack_error)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [14:0] crc_step(input logic [14:0] c, input logic b);
        logic [14:0] r;
        r = {c[13:0], 1'b0};
        if (b ^ c[14]) r = r ^ 15'h4599;
        return r;
    endfunction

    task automatic push(input logic b, input logic [1:0] cl);
        exp_b[exp_len] = b;
        exp_c[exp_len] = cl;
        exp_len++;
    endtask

    task automatic build(input logic ide, input logic rtr, input logic [28:0] id,
                         input logic [3:0] dlc, input logic [63:0] data);
        logic [14:0] crc;
        int nb;
        exp_len = 0;
        push(1'b0, 2'd1);
        for (int i = 28; i >= 18; i--) push(id[i], 2'd1);
        if (ide) begin
            push(1'b1, 2'd1);
            push(1'b1, 2'd1);
            for (int i = 17; i >= 0; i--) push(id[i], 2'd1);
            push(rtr, 2'd1);
            push(1'b0, 2'd1);
            push(1'b0, 2'd1);
        end else begin
            push(rtr, 2'd1);
            push(1'b0, 2'd1);
            push(1'b0, 2'd1);
        end
        for (int i = 3; i >= 0; i--) push(dlc[i], 2'd1);
        hdr_len = exp_len;
        nb = rtr ? 0 : ((dlc > 4'd8) ? 8 : int'(dlc));
        pay_bits = nb * 8;
        for (int k = 0; k < nb; k++)
            for (int j = 7; j >= 0; j--) push(data[8*k+j], 2'd1);
        crc = '0;
        for (int i = 0; i < exp_len; i++) crc = crc_step(crc, exp_b[i]);
        for (int i = 14; i >= 0; i--) push(crc[i], 2'd1);
        for (int i = 0; i < 10; i++) push(1'b1, 2'd2);
    endtask

    function automatic string tag_of(input int i, input logic ide);
        if (i == 0) return "R2";
        if (i < hdr_len) return ide ? "R4" : "R3";
        if (i < hdr_len + pay_bits) return "R5";
        if (i < hdr_len + pay_bits + 15) return "R6";
        return "R7";
    endfunction

    task automatic strobe();
        @(negedge clk) bit_strobe = 1'b1;
        @(negedge clk) bit_strobe = 1'b0;
    endtask

    task automatic run_frame(input logic ide, input logic rtr, input logic [28:0] id,
                             input logic [3:0] dlc, input logic [63:0] data,
                             input logic ack_dom, input logic poke);
        build(ide, rtr, id, dlc, data);
        @(negedge clk);
        req_valid = 1'b1; req_ide = ide; req_rtr = rtr; req_id = id;
        req_dlc = dlc; req_data = data;
        @(negedge clk);
        req_valid = 1'b0;
        req_ide = ~ide; req_rtr = ~rtr; req_id = ~id; req_dlc = ~dlc; req_data = ~data;
        chk("R1", "busy after accept", 32'(busy), 32'd1);
        chk("R1", "tx before first strobe", 32'(tx_bit), 32'd1);
        for (int i = 0; i < exp_len; i++) begin
            strobe();
            chk(tag_of(i, ide), $sformatf("bit %0d", i), 32'(tx_bit), 32'(exp_b[i]));
            chk("R8", $sformatf("class %0d", i), 32'(field_class), 32'(exp_c[i]));
            chk("R10", "no early done", 32'(done), 32'd0);
            if (i == exp_len - 9) bus_rx = ack_dom ? 1'b0 : 1'b1;
            else                  bus_rx = tx_bit;
            if (poke && i == 3) begin
                req_valid = 1'b1;
                @(negedge clk) req_valid = 1'b0;
            end
            if (i % 7 == 2) begin
                @(negedge clk);
                chk("R2", "hold without strobe", 32'(tx_bit), 32'(exp_b[i]));
            end
        end
        strobe();
        chk("R10", "done pulse", 32'(done), 32'd1);
        chk("R10", "busy fall", 32'(busy), 32'd0);
        chk("R10", "tx idle", 32'(tx_bit), 32'd1);
        chk("R10", "class idle", 32'(field_class), 32'd0);
        chk("R9", "ack_ok", 32'(ack_ok), 32'(ack_dom));
        chk("R9", "ack_error", 32'(ack_error), 32'(!ack_dom));
        @(negedge clk);
        chk("R10", "done one cycle", 32'(done), 32'd0);
        chk("R1", "idle tx", 32'(tx_bit), 32'd1);
        bus_rx = 1'b1;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_cmp++; n_bad++;
        $display("FAIL R10 watchdog: actual hung expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        chk("R1", "reset tx", 32'(tx_bit), 32'd1);
        chk("R1", "reset busy", 32'(busy), 32'd0);
        chk("R8", "reset class", 32'(field_class), 32'd0);
        rst_n = 1'b1;
        // strobes while idle do nothing
        strobe();
        chk("R1", "idle strobe", 32'(tx_bit), 32'd1);
        chk("R1", "idle strobe busy", 32'(busy), 32'd0);
        // directed corners
        run_frame(1'b0, 1'b0, 29'h1FFC_0000, 4'd0, 64'h0, 1'b1, 1'b0);
        run_frame(1'b0, 1'b0, 29'h0AB4_0000, 4'd8, 64'h0123_4567_89AB_CDEF, 1'b1, 1'b1);
        run_frame(1'b0, 1'b0, 29'h0, 4'd15, 64'hFFFF_0000_A5A5_5A5A, 1'b0, 1'b0);
        run_frame(1'b0, 1'b1, 29'h1234_5678, 4'd5, 64'hDEAD_BEEF_CAFE_F00D, 1'b1, 1'b0);
        run_frame(1'b1, 1'b0, 29'h1FFF_FFFF, 4'd8, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 1'b1);
        run_frame(1'b1, 1'b0, 29'h0, 4'd0, 64'h0, 1'b0, 1'b0);
        run_frame(1'b1, 1'b1, 29'h0F0F_0F0F, 4'd12, 64'h1111_2222_3333_4444, 1'b1, 1'b0);
        run_frame(1'b1, 1'b0, 29'h1555_5555, 4'd9, 64'h8000_0000_0000_0001, 1'b1, 1'b0);
        // random mix
        for (int n = 0; n < 30; n++) begin
            run_frame(1'($urandom), 1'(($urandom % 4) == 0), 29'($urandom),
                      4'($urandom), {$urandom, $urandom}, 1'(($urandom % 5) != 0),
                      1'(($urandom % 3) == 0));
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule